// File: doc/BRIEF.md
# Dual-Buffer Ethernet Receive Controller

This block takes received Ethernet frames from a byte-wide stream and stores each one into one of two receive buffers, used strictly in turn, starting with buffer 0 after reset. Each buffer has a status word with a completion flag and an interrupt enable. The flag is raised when the last byte of a frame has been stored. While the flag is up, the hardware will not write to that buffer again. Software reads the frame through a 32-bit word-addressed port and then writes the flag back to zero, which hands the buffer back to the hardware.

If the buffer that is next in turn is still held when a new frame begins, the whole frame is discarded and a drop counter advances. This happens even when the other buffer is free. Bytes beyond the buffer capacity of 1518 are thrown away, so the frame cannot spill into the neighbouring buffer. A single interrupt line combines a global enable with the per-buffer flag and enable pairs.

The stream marks a frame with `rx_valid` on every byte and `rx_last` on its final byte. The first valid byte after a final byte (or after reset) opens a new frame. Bus reads return data on the cycle after the request.

Top module: `rx_pingpong_ctrl`

## Requirements
- R1: After reset, both status words and the global enable word read 0, `irq` is 0, `drop_count` is 0, and the first frame goes to buffer 0.
- R2: Byte k of a stored frame is held in word k/4 of its buffer, in bits 8*(k%4)+7 down to 8*(k%4). Buffer 0 word w is at byte address 0x1000+4*w and buffer 1 word w is at 0x1800+4*w. Lanes above the last byte in the final word read 0. Read data appears on `bus_rdata` one cycle after the request.
- R3: Accepted frames alternate between buffers: after a frame is accepted into buffer b, the next accepted frame goes to the other buffer. A dropped frame does not advance this order.
- R4: The cycle after the last byte of an accepted frame, bit 0 (done) of that buffer's status word reads 1. Status words are at 0x17FC (buffer 0) and 0x1FFC (buffer 1).
- R5: A done bit stays 1 until software writes its status word with bit 0 at 0. Writing bit 0 as 1 does not change it. Bit 3 of the status word is a read/write interrupt enable.
- R6: A frame that starts while the buffer next in turn has done set is discarded whole. Both buffers' contents and done bits are unchanged, and `drop_count` increments by one.
- R7: Bytes 0 to 1517 of a longer frame are stored and the rest are discarded. Done is still set on the last byte, and the other buffer is not touched.
- R8: `irq` is 1 exactly when bit 31 of the global enable word at 0x17F8 is 1 and, for at least one buffer, both the done bit and the enable bit are 1.
- R9: The frame bytes at offsets 12 and 13 (the type/length field, high byte first on the wire) read from word address 0x100C as bits 7:0 and 15:8 respectively.
- R10: Reads of offsets outside the stored words, the status words and the global enable word return 0. In a status word, every bit other than 0 and 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | A received byte is present on `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | The present byte is the last of its frame |
| bus_en | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 13 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq | output | 1 | Receive interrupt |
| drop_count | output | DROP_W | Count of discarded frames, wrapping |

## Verification
The in-line properties check the following on every cycle:
- the capture logic never writes into a buffer whose done bit is up;
- a done bit rises only on a frame-completion pulse for that buffer;
- a done bit falls only on a software clear of that buffer;
- the drop counter moves by at most one step;
- no store address leaves the buffer.

The bench scenarios are what show the remaining behaviour:
- the byte-lane packing and zeroed upper lanes;
- the strict turn order, including a frame dropped while the other buffer is free;
- truncation at 1518 bytes;
- the interrupt combination;
- the read-as-zero offsets.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
  // Fixed address map: bit 12 selects the buffer area, bit 11 the buffer,
  // bits 10:2 the word inside a 2 KiB window.
  localparam int unsigned BUS_AW   = 13;
  localparam int unsigned WIN_W    = 9;
  localparam logic [WIN_W-1:0] STAT_WORD = 9'h1FF;
  localparam logic [WIN_W-1:0] GIE_WORD  = 9'h1FE;
  localparam int unsigned DONE_BIT = 0;
  localparam int unsigned IE_BIT   = 3;
  localparam int unsigned GIE_BIT  = 31;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_MEM,
    RD_STAT0,
    RD_STAT1,
    RD_GIE
  } rd_src_e;
endpackage

// File: rtl/rxpp_capture.sv
module rxpp_capture #(
  parameter int unsigned MAX_BYTES = 1518,
  parameter int unsigned DROP_W    = 8,
  parameter int unsigned IDX_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic [1:0]        done_i,
  output logic              wr_en,
  output logic              wr_buf,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [7:0]        wr_byte,
  output logic              set_en,
  output logic              set_buf,
  output logic [DROP_W-1:0] drop_count
);
  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(MAX_BYTES);

  logic              in_frame_q, in_frame_d;
  logic              keep_q, keep_d;
  logic              tgt_q, tgt_d;
  logic              nxt_q, nxt_d;
  logic [IDX_W-1:0]  cnt_q, cnt_d;
  logic [DROP_W-1:0] drop_q, drop_d;

  logic             start, accept_start, keep_now, room;
  logic [IDX_W-1:0] idx_now;

  always_comb begin
    start        = rx_valid & ~in_frame_q;
    accept_start = start & ~done_i[nxt_q];
    keep_now     = in_frame_q ? keep_q : accept_start;
    idx_now      = in_frame_q ? cnt_q : '0;
    room         = (idx_now < LIMIT);

    wr_en   = rx_valid & keep_now & room;
    wr_buf  = in_frame_q ? tgt_q : nxt_q;
    wr_idx  = idx_now;
    wr_byte = rx_data;
    set_en  = rx_valid & rx_last & keep_now;
    set_buf = wr_buf;

    in_frame_d = ~rx_last;
    keep_d     = start ? accept_start : keep_q;
    tgt_d      = accept_start ? nxt_q : tgt_q;
    nxt_d      = accept_start ? ~nxt_q : nxt_q;
    cnt_d      = room ? idx_now + 1'b1 : idx_now;
    drop_d     = (start & done_i[nxt_q]) ? drop_q + 1'b1 : drop_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      keep_q     <= 1'b0;
      tgt_q      <= 1'b0;
      nxt_q      <= 1'b0;
      cnt_q      <= '0;
    end else if (rx_valid) begin
      in_frame_q <= in_frame_d;
      keep_q     <= keep_d;
      tgt_q      <= tgt_d;
      nxt_q      <= nxt_d;
      cnt_q      <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drop_q <= '0;
    else        drop_q <= drop_d;
  end

  assign drop_count = drop_q;

  // R6: hardware never stores into a buffer software still holds
  a_r6_write_free_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !done_i[wr_buf]);

  // R6: the discard counter advances by single steps
  a_r6_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_q != $past(drop_q)) |-> (drop_q == $past(drop_q) + 1'b1));
endmodule

// File: rtl/rxpp_store.sv
module rxpp_store
  import rxpp_pkg::*;
#(
  parameter int unsigned WORDS = 380,
  parameter int unsigned IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_buf,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_byte,
  input  logic             rd_en,
  input  logic             rd_buf,
  input  logic [WIN_W-1:0] rd_word,
  output logic [31:0]      rd_q
);
  localparam int unsigned DEPTH  = 2 * WORDS;
  localparam int unsigned MEM_AW = $clog2(DEPTH);
  localparam logic [MEM_AW-1:0] HALF = MEM_AW'(WORDS);

  logic [3:0][7:0] mem [DEPTH];

  logic [MEM_AW-1:0] wa, ra;
  logic [1:0]        lane;

  always_comb begin
    lane = wr_idx[1:0];
    wa   = (wr_buf ? HALF : '0) + MEM_AW'(wr_idx[IDX_W-1:2]);
    ra   = (rd_buf ? HALF : '0) + MEM_AW'(rd_word);
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (lane == 2'd0) mem[wa] <= {24'h0, wr_byte};
      else              mem[wa][lane] <= wr_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= mem[ra];
  end

  // R7: a stored byte always lands inside its own buffer
  a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (MEM_AW'(wr_idx[IDX_W-1:2]) < HALF));
endmodule

// File: rtl/rxpp_regs.sv
module rxpp_regs
  import rxpp_pkg::*;
#(
  parameter int unsigned WORDS = 380
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              set_en,
  input  logic              set_buf,
  input  logic [31:0]       mem_q,
  output logic [1:0]        done_o,
  output logic              irq,
  output logic [31:0]       bus_rdata,
  output logic              rd_en,
  output logic              rd_buf,
  output logic [WIN_W-1:0]  rd_word
);
  logic [1:0]  done_q, done_d, ie_q, ie_d, stat_wr, clr_hit;
  logic        gie_q, gie_d;
  rd_src_e     src_q, src_d;
  logic [31:0] reg_q, reg_d;

  logic             in_area, bsel, is_stat, is_gie, is_mem, rd_req, wr_req;
  logic [WIN_W-1:0] widx;
  logic             unused_bus;

  assign unused_bus = ^{bus_addr[1:0], bus_wdata[30:4], bus_wdata[2:1]};

  always_comb begin
    in_area = bus_addr[12];
    bsel    = bus_addr[11];
    widx    = bus_addr[10:2];
    is_stat = in_area & (widx == STAT_WORD);
    is_gie  = in_area & ~bsel & (widx == GIE_WORD);
    is_mem  = in_area & (widx < WIN_W'(WORDS));
    rd_req  = bus_en & ~bus_we;
    wr_req  = bus_en & bus_we;

    for (int b = 0; b < 2; b++) begin
      stat_wr[b] = wr_req & is_stat & (bsel == 1'(b));
      clr_hit[b] = stat_wr[b] & ~bus_wdata[DONE_BIT];
      if (set_en && (set_buf == 1'(b))) done_d[b] = 1'b1;
      else if (clr_hit[b])              done_d[b] = 1'b0;
      else                              done_d[b] = done_q[b];
      ie_d[b] = stat_wr[b] ? bus_wdata[IE_BIT] : ie_q[b];
    end
    gie_d = (wr_req & is_gie) ? bus_wdata[GIE_BIT] : gie_q;

    src_d = src_q;
    reg_d = reg_q;
    if (rd_req) begin
      reg_d = '0;
      if (is_mem) begin
        src_d = RD_MEM;
      end else if (is_stat) begin
        src_d = bsel ? RD_STAT1 : RD_STAT0;
        reg_d[DONE_BIT] = done_q[bsel];
        reg_d[IE_BIT]   = ie_q[bsel];
      end else if (is_gie) begin
        src_d = RD_GIE;
        reg_d[GIE_BIT] = gie_q;
      end else begin
        src_d = RD_NONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= '0;
      ie_q   <= '0;
      gie_q  <= 1'b0;
      src_q  <= RD_NONE;
      reg_q  <= '0;
    end else begin
      done_q <= done_d;
      ie_q   <= ie_d;
      gie_q  <= gie_d;
      if (rd_req) begin
        src_q <= src_d;
        reg_q <= reg_d;
      end
    end
  end

  assign done_o    = done_q;
  assign irq       = gie_q & |(done_q & ie_q);
  assign bus_rdata = (src_q == RD_MEM) ? mem_q : reg_q;
  assign rd_en     = rd_req & is_mem;
  assign rd_buf    = bsel;
  assign rd_word   = widx;

  for (genvar gb = 0; gb < 2; gb++) begin : g_done_chk
    // R4: a done bit rises only on completion of a frame in that buffer
    a_r4_set_by_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q[gb]) |-> $past(set_en && (set_buf == 1'(gb))));
    // R5: a done bit falls only on a software clear of that buffer
    a_r5_clear_by_sw: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done_q[gb]) |-> $past(clr_hit[gb]));
  end
endmodule

// File: rtl/rx_pingpong_ctrl.sv
module rx_pingpong_ctrl
  import rxpp_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 1518,
  parameter int unsigned DROP_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [12:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic [DROP_W-1:0] drop_count
);
  localparam int unsigned WORDS = (MAX_BYTES + 3) / 4;
  localparam int unsigned IDX_W = $clog2(MAX_BYTES + 1);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic             wr_en, wr_buf, set_en, set_buf, rd_en, rd_buf;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_byte;
  logic [1:0]       done;
  logic [31:0]      mem_q;
  logic [WIN_W-1:0] rd_word;

  rxpp_capture #(
    .MAX_BYTES(MAX_BYTES),
    .DROP_W   (DROP_W),
    .IDX_W    (IDX_W)
  ) i_capture (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_last   (rx_last),
    .done_i    (done),
    .wr_en     (wr_en),
    .wr_buf    (wr_buf),
    .wr_idx    (wr_idx),
    .wr_byte   (wr_byte),
    .set_en    (set_en),
    .set_buf   (set_buf),
    .drop_count(drop_count)
  );

  rxpp_store #(
    .WORDS(WORDS),
    .IDX_W(IDX_W)
  ) i_store (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .wr_en  (wr_en),
    .wr_buf (wr_buf),
    .wr_idx (wr_idx),
    .wr_byte(wr_byte),
    .rd_en  (rd_en),
    .rd_buf (rd_buf),
    .rd_word(rd_word),
    .rd_q   (mem_q)
  );

  rxpp_regs #(
    .WORDS(WORDS)
  ) i_regs (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .set_en   (set_en),
    .set_buf  (set_buf),
    .mem_q    (mem_q),
    .done_o   (done),
    .irq      (irq),
    .bus_rdata(bus_rdata),
    .rd_en    (rd_en),
    .rd_buf   (rd_buf),
    .rd_word  (rd_word)
  );
endmodule

// File: tb/test_rx_pingpong_ctrl.sv
module test_rx_pingpong_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB  = 1518;
  localparam int WORDS = (MAXB + 3) / 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid, rx_last, bus_en, bus_we, irq;
  logic [7:0]  rx_data, drop_count;
  logic [12:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_pingpong_ctrl i_rx_pingpong_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .drop_count(drop_count)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [31:0] exp_mem [2][WORDS];
  int          mlen [2];
  bit          mdone [2];
  bit          mie [2];
  bit          mgie;
  bit          mnxt;
  int          mdrop;
  logic [7:0]  fb [1600];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  function automatic logic [31:0] stat_word(input int b);
    return {28'h0, mie[b], 2'b00, mdone[b]};
  endfunction

  function automatic logic irq_model();
    return mgie & ((mdone[0] & mie[0]) | (mdone[1] & mie[1]));
  endfunction

  task automatic make_frame(input int len);
    for (int k = 0; k < len; k++) fb[k] = 8'($urandom);
  endtask

  task automatic send_frame(input int len);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = fb[k]; rx_last = (k == len - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  // Reference: strict turn order, drop when the buffer in turn is held
  task automatic model_frame(input int len, output int acc);
    int n;
    if (mdone[mnxt]) begin
      mdrop++;
      acc = -1;
    end else begin
      acc = int'(mnxt);
      n = (len < MAXB) ? len : MAXB;
      for (int k = 0; k < n; k++) begin
        if (k % 4 == 0) exp_mem[acc][k / 4] = {24'h0, fb[k]};
        else            exp_mem[acc][k / 4][8 * (k % 4) +: 8] = fb[k];
      end
      mlen[acc]  = n;
      mdone[acc] = 1'b1;
      mnxt       = ~mnxt;
    end
  endtask

  task automatic sw_stat(input int b, input logic [31:0] v);
    bus_write(b ? 13'h1FFC : 13'h17FC, v);
    if (!v[0]) mdone[b] = 1'b0;
    mie[b] = v[3];
  endtask

  task automatic verify_buf(input int b, input string tag);
    logic [31:0] d, fa, fe;
    int bad = 0;
    int nw = (mlen[b] + 3) / 4;
    fa = '0; fe = '0;
    if (nw == 0) return;
    for (int w = 0; w < nw; w++) begin
      bus_read(13'(32'h1000 + b * 32'h800 + 4 * w), d);
      if (d !== exp_mem[b][w] && bad == 0) begin
        fa = d; fe = exp_mem[b][w];
        bad++;
      end
    end
    check(tag, fa, fe);
  endtask

  task automatic check_status(input string tag);
    logic [31:0] d;
    bus_read(13'h17FC, d); check({tag, " status0"}, d, stat_word(0));
    bus_read(13'h1FFC, d); check({tag, " status1"}, d, stat_word(1));
    check({tag, " R8 irq"}, 32'(irq), 32'(irq_model()));
    check({tag, " R6 drop_count"}, 32'(drop_count), 32'(8'(mdrop)));
  endtask

  task automatic run_frame(input int len, input string tag);
    int acc;
    make_frame(len);
    send_frame(len);
    model_frame(len, acc);
    if (acc >= 0) verify_buf(acc, {tag, " R2 contents"});
    else          verify_buf(int'(mnxt), {tag, " R6 untouched"});
    check_status(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int acc, seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    rst_n = 1'b0; rx_valid = 1'b0; rx_last = 1'b0; rx_data = '0;
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    mdone[0] = 0; mdone[1] = 0; mie[0] = 0; mie[1] = 0; mgie = 0;
    mnxt = 0; mdrop = 0; mlen[0] = 0; mlen[1] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check_status("R1 reset");
    bus_read(13'h17F8, d); check("R1 global enable", d, 32'h0);

    // R9 / R4 / R2: first frame lands in buffer 0 with type field
    make_frame(64);
    fb[12] = 8'h08; fb[13] = 8'h00;
    send_frame(64);
    model_frame(64, acc);
    check("R1 first frame buffer", 32'(acc), 32'd0);
    check_status("R4 after frame 1");
    bus_read(13'h100C, d); check("R9 type field", {16'h0, d[15:0]}, 32'h0000_0008);
    verify_buf(0, "R2 frame 1 contents");

    // R3 / R2: second frame alternates to buffer 1, short tail zeroed
    make_frame(7);
    send_frame(7);
    model_frame(7, acc);
    check("R3 second frame buffer", 32'(acc), 32'd1);
    bus_read(13'h1804, d); check("R2 zero upper lanes", d, {8'h00, fb[6], fb[5], fb[4]});
    check_status("R4 after frame 2");

    // R6: both held, frame discarded
    run_frame(20, "R6 both full");
    verify_buf(0, "R6 buffer 0 kept");
    verify_buf(1, "R6 buffer 1 kept");

    // R5: writing bit 0 as 1 leaves done set
    sw_stat(0, 32'h1);
    check_status("R5 write one keeps done");

    // R8: interrupt combination
    bus_write(13'h17F8, 32'h8000_0000); mgie = 1'b1;
    check("R8 enable without ie", 32'(irq), 32'd0);
    sw_stat(1, 32'h9);
    check("R8 irq on done1 ie1", 32'(irq), 32'd1);
    bus_read(13'h17F8, d); check("R8 global enable readback", d, 32'h8000_0000);
    sw_stat(0, 32'h0);
    check_status("R5 clear done0");

    // R7: oversize frame goes to buffer 0 (drop did not advance order)
    make_frame(1600);
    send_frame(1600);
    model_frame(1600, acc);
    check("R3 order after drop", 32'(acc), 32'd0);
    bus_read(13'(32'h1000 + 4 * (WORDS - 1)), d);
    check("R7 last word", d, {16'h0, fb[1517], fb[1516]});
    verify_buf(0, "R7 truncated contents");
    verify_buf(1, "R7 other buffer kept");
    check_status("R7 done on oversize");

    // R10: unmapped reads
    bus_read(13'h0000, d); check("R10 low area", d, 32'h0);
    bus_read(13'h1640, d); check("R10 beyond words", d, 32'h0);
    bus_read(13'h1FF8, d); check("R10 buffer1 spare word", d, 32'h0);

    // R3 / R6: buffer in turn held while the other is free -> drop
    sw_stat(0, 32'h0);
    run_frame(30, "R3 strict order drop");
    check("R6 other free stays free", 32'(mdone[0]), 32'd0);

    // Random phase
    for (int it = 0; it < 40; it++) begin
      int r = int'($urandom % 4);
      if (r < 3) begin
        int len = (($urandom % 8) == 0) ? 1519 + int'($urandom % 80)
                                          : 1 + int'($urandom % 200);
        run_frame(len, "R3 random frame");
      end else begin
        int b = int'($urandom % 2);
        sw_stat(b, {28'h0, 1'($urandom), 3'b000});
        if (($urandom % 4) == 0) begin
          mgie = 1'($urandom);
          bus_write(13'h17F8, {mgie, 31'h0});
        end
        check_status("R5 random clear");
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule